// File: doc/BRIEF.md
# Timer with Capture, Compare and Reload Channels

This block is a 16-bit up-counter with four 16-bit channel registers. Each channel can capture the count, compare against it, or simply hold a value. The counter has four clock sources: stopped, the internal machine-cycle tick, the tick divided by two, or falling edges of an external count pin. A gate pin can qualify the internal tick. Channel 0 also serves as the reload value. The counter can be reloaded when it overflows or on a falling edge of an external reload pin.

Software reaches the block through a flat byte-wide register port. Writes take effect at the clock edge and reads are combinational. All pin inputs pass through two-flop synchronisers before any edge detection. The block keeps sticky event flags for overflow, external reload and each channel. These flags are meant to feed an interrupt controller outside the block.

Register map: 0 control, 1 channel modes, 2 auxiliary, 3 flags, 4/5 count low/high, 6+2k / 7+2k channel k low/high.

Top module: `cc_timer`

## Requirements
- R1: After reset the count, every channel register, every flag and every compare output read 0.
- R2: Control bits [1:0] select the count source: 00 stops the counter and 01 adds one per cycle in which `tick_i` is high.
- R3: Source 10 adds one on every second tick. Any write to the control register restarts the divider, so that n ticks then give n/2 counts, rounded down.
- R4: With control bit 2 set, internal ticks are counted only while the synchronised `gate_i` is high.
- R5: Source 11 counts each falling edge of `count_i`, after two-flop synchronisation, and ignores `tick_i`.
- R6: A count step from 0xFFFF goes to 0x0000 and sets the overflow flag (flag bit 0, `ovf_flag_o`).
- R7: With control bit 3 set and bit 4 clear, the overflow step loads the channel 0 value instead of 0.
- R8: With control bit 4 set, a falling edge on `reload_i` sets the reload flag (flag bit 1). The edge also loads the channel 0 value into the counter, but only when bit 3 is set.
- R9: A channel in capture mode (mode field 01) latches the count on its pin edge and sets its flag (flag bit 2+k), provided control bit 5 is clear. Auxiliary bit k chooses the edge: 1 for rising, 0 for falling.
- R10: With control bit 5 set, a write to the low byte of a capture-mode channel latches the count and discards the write data, and it sets the channel flag. A high-byte write stores its data normally.
- R11: In compare mode (field 10) with control bit 6 clear, the output goes high once the count equals the channel value and goes low on overflow. Each match sets the channel flag.
- R12: In compare mode with control bit 6 set, a match drives the output to auxiliary bit 4+k, and overflow leaves the output unchanged.
- R13: Flags are sticky. Writing 1 to a flag-register bit clears that flag, and writing 0 leaves it unchanged.
- R14: A channel with mode field 00 drives its output low, ignores pin edges and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal machine-cycle tick |
| gate_i | input | 1 | Gate pin for internal counting |
| count_i | input | 1 | External count pin |
| reload_i | input | 1 | External reload pin |
| cap_i | input | 4 | Per-channel capture pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| cmp_o | output | 4 | Per-channel compare outputs |
| ovf_flag_o | output | 1 | Overflow flag |
| rld_flag_o | output | 1 | External reload flag |
| ch_flag_o | output | 4 | Per-channel event flags |

## Verification
Several properties are checked on every cycle:
- each count step is exactly +1;
- the count holds when there is no event;
- the wrap and reload targets are correct;
- a capture takes the current count;
- overflow clears a compare output in mode 0, and that output is otherwise held between matches;
- an off channel drives its output low;
- flags stay set unless software clears them.

Other behaviour shows only in the bench scenarios: the divide-by-two phase, gating latency, counting of external edges, the per-channel choice of edge polarity, and the discarding of write data on a capture-by-write. The bench also sweeps the count step by step past staggered compare values.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  typedef enum logic [1:0] {
    CH_OFF     = 2'b00,
    CH_CAPTURE = 2'b01,
    CH_COMPARE = 2'b10,
    CH_HOLD    = 2'b11
  } ch_mode_e;

  typedef enum logic [1:0] {
    SRC_STOP      = 2'b00,
    SRC_TICK      = 2'b01,
    SRC_TICK_DIV2 = 2'b10,
    SRC_EXT       = 2'b11
  } cnt_src_e;

  // Control register layout, packed MSB first: bit 6 down to bits 1:0.
  typedef struct packed {
    logic     cmp_sw;   // 6: software-level compare mode
    logic     cap_wr;   // 5: capture on low-byte write
    logic     rld_ext;  // 4: reload from external pin
    logic     rld_en;   // 3: reload enable
    logic     gate_en;  // 2: gate the internal tick
    cnt_src_e src;      // 1:0 count source
  } ctrl_t;

  localparam int CTRL_BITS = 7;

endpackage

// File: rtl/cc_timer_sync.sv
module cc_timer_sync #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  // A detected edge always reflects a level seen one cycle earlier.
  p_fall_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |-> (|$past(s2_q)));
endmodule

// File: rtl/cc_timer_counter.sv
module cc_timer_counter
  import cc_timer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  cnt_src_e      src,
  input  logic          gate_en,
  input  logic          gate_lvl,
  input  logic          ext_fall,
  input  logic          pre_clr,
  input  logic          rld_en,
  input  logic          rld_ext,
  input  logic          rld_fall,
  input  logic [2*DW-1:0] rld_val,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [2*DW-1:0] cnt,
  output logic          ovf_evt
);
  localparam int CW = 2 * DW;
  localparam logic [CW-1:0] TOP = '1;

  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  function automatic logic at_top(input logic [CW-1:0] c);
    return c == TOP;
  endfunction

  logic [CW-1:0] cnt_q;
  logic          pre_q, gate_ok, adv, cnt_wr, ext_load, wrap_reload;

  always_comb begin
    gate_ok = !gate_en || gate_lvl;
    unique case (src)
      SRC_STOP:      adv = 1'b0;
      SRC_TICK:      adv = tick && gate_ok;
      SRC_TICK_DIV2: adv = tick && gate_ok && pre_q;
      default:       adv = ext_fall;
    endcase
  end

  assign cnt_wr      = wr_lo || wr_hi;
  assign ext_load    = rld_en && rld_ext && rld_fall;
  assign wrap_reload = rld_en && !rld_ext;
  assign ovf_evt     = adv && at_top(cnt_q) && !cnt_wr && !ext_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= 1'b0;
    else if (pre_clr) pre_q <= 1'b0;
    else if (src == SRC_TICK_DIV2 && tick && gate_ok) pre_q <= ~pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      if (wr_lo) cnt_q[DW-1:0]  <= wdata;
      if (wr_hi) cnt_q[CW-1:DW] <= wdata;
    end else if (ext_load) begin
      cnt_q <= rld_val;
    end else if (adv) begin
      if (at_top(cnt_q)) cnt_q <= wrap_reload ? rld_val : '0;
      else               cnt_q <= step_count(cnt_q);
    end
  end

  assign cnt = cnt_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !at_top(cnt_q) && !cnt_wr && !ext_load) |=> cnt_q == $past(cnt_q) + CW'(1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !cnt_wr && !ext_load) |=> $stable(cnt_q));
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !wrap_reload) |=> cnt_q == '0);
  p_wrap_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && wrap_reload) |=> cnt_q == $past(rld_val));
  p_ext_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_load && !cnt_wr) |=> cnt_q == $past(rld_val));
endmodule

// File: rtl/cc_timer_channel.sv
module cc_timer_channel
  import cc_timer_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ch_mode_e        mode,
  input  logic            cap_wr_sel,
  input  logic            cmp_sw,
  input  logic            sw_lvl,
  input  logic            pol,
  input  logic            pin_rise,
  input  logic            pin_fall,
  input  logic [2*DW-1:0] cnt,
  input  logic            ovf_evt,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] value,
  output logic            cmp_out,
  output logic            hit
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] val_q;
  logic          out_q, pin_evt, cap_pin, cap_soft, match;

  assign pin_evt  = pol ? pin_rise : pin_fall;
  assign cap_pin  = (mode == CH_CAPTURE) && !cap_wr_sel && pin_evt;
  assign cap_soft = (mode == CH_CAPTURE) && cap_wr_sel && wr_lo;
  assign match    = (mode == CH_COMPARE) && (cnt == val_q);
  assign hit      = cap_pin || cap_soft || match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (cap_soft) begin
      val_q <= cnt;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) val_q[DW-1:0]  <= wdata;
      if (wr_hi) val_q[CW-1:DW] <= wdata;
    end else if (cap_pin) begin
      val_q <= cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  out_q <= 1'b0;
    else if (mode != CH_COMPARE) out_q <= 1'b0;
    else if (cmp_sw) begin
      if (match) out_q <= sw_lvl;
    end else if (ovf_evt)        out_q <= 1'b0;
    else if (match)              out_q <= 1'b1;
  end

  assign value   = val_q;
  assign cmp_out = out_q;

  p_cap_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pin && !wr_lo && !wr_hi) |=> val_q == $past(cnt));
  p_cap_soft_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_soft |=> val_q == $past(cnt));
  p_cmp_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_COMPARE && !cmp_sw && ovf_evt) |=> !out_q);
  p_cmp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_COMPARE && cmp_sw && !match) |=> out_q == $past(out_q));
  p_off_low_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CH_OFF) |=> !out_q);
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           gate_i,
  input  logic           count_i,
  input  logic           reload_i,
  input  logic [NCH-1:0] cap_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] cmp_o,
  output logic           ovf_flag_o,
  output logic           rld_flag_o,
  output logic [NCH-1:0] ch_flag_o
);
  localparam int CW        = 2 * DW;
  localparam int NS        = NCH + 3;
  localparam int FW        = NCH + 2;
  localparam int A_CTRL    = 0;
  localparam int A_MODE    = 1;
  localparam int A_AUX     = 2;
  localparam int A_FLAG    = 3;
  localparam int A_CNT     = 4;
  localparam int A_CH_BASE = 6;
  localparam int I_RLD     = NCH;
  localparam int I_CNT     = NCH + 1;
  localparam int I_GATE    = NCH + 2;

  ctrl_t          ctrl_q;
  logic [DW-1:0]  mode_q, aux_q;
  logic [FW-1:0]  flag_q, flag_set, flag_clr;
  logic [NS-1:0]  s_lvl, s_rise, s_fall;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  ch_val [NCH];
  logic [NCH-1:0] ch_hit;
  logic           ovf_evt, rld_evt, ctrl_wr, sync_unused;

  function automatic logic hit_addr(input logic [AW-1:0] a, input int target);
    return a == AW'(target);
  endfunction

  cc_timer_sync #(.N(NS)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .pin ({gate_i, count_i, reload_i, cap_i}),
    .lvl (s_lvl), .rise (s_rise), .fall (s_fall)
  );
  assign sync_unused = ^{s_lvl[I_CNT:0], s_rise[I_GATE:I_RLD], s_fall[I_GATE]};

  assign ctrl_wr = wr_en_i && hit_addr(addr_i, A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      aux_q  <= '0;
    end else if (wr_en_i) begin
      if (hit_addr(addr_i, A_CTRL)) ctrl_q <= ctrl_t'(wdata_i[CTRL_BITS-1:0]);
      if (hit_addr(addr_i, A_MODE)) mode_q <= wdata_i;
      if (hit_addr(addr_i, A_AUX))  aux_q  <= wdata_i;
    end
  end

  cc_timer_counter #(.DW(DW)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .src      (ctrl_q.src),
    .gate_en  (ctrl_q.gate_en),
    .gate_lvl (s_lvl[I_GATE]),
    .ext_fall (s_fall[I_CNT]),
    .pre_clr  (ctrl_wr),
    .rld_en   (ctrl_q.rld_en),
    .rld_ext  (ctrl_q.rld_ext),
    .rld_fall (s_fall[I_RLD]),
    .rld_val  (ch_val[0]),
    .wr_lo    (wr_en_i && hit_addr(addr_i, A_CNT)),
    .wr_hi    (wr_en_i && hit_addr(addr_i, A_CNT + 1)),
    .wdata    (wdata_i),
    .cnt      (cnt),
    .ovf_evt  (ovf_evt)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    cc_timer_channel #(.DW(DW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (ch_mode_e'(mode_q[2*k +: 2])),
      .cap_wr_sel (ctrl_q.cap_wr),
      .cmp_sw     (ctrl_q.cmp_sw),
      .sw_lvl     (aux_q[NCH + k]),
      .pol        (aux_q[k]),
      .pin_rise   (s_rise[k]),
      .pin_fall   (s_fall[k]),
      .cnt        (cnt),
      .ovf_evt    (ovf_evt),
      .wr_lo      (wr_en_i && hit_addr(addr_i, A_CH_BASE + 2*k)),
      .wr_hi      (wr_en_i && hit_addr(addr_i, A_CH_BASE + 2*k + 1)),
      .wdata      (wdata_i),
      .value      (ch_val[k]),
      .cmp_out    (cmp_o[k]),
      .hit        (ch_hit[k])
    );
  end

  assign rld_evt  = ctrl_q.rld_ext && s_fall[I_RLD];
  assign flag_set = {ch_hit, rld_evt, ovf_evt};
  assign flag_clr = (wr_en_i && hit_addr(addr_i, A_FLAG)) ? wdata_i[FW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign ovf_flag_o = flag_q[0];
  assign rld_flag_o = flag_q[1];
  assign ch_flag_o  = flag_q[FW-1:2];

  always_comb begin
    rdata_o = '0;
    if (hit_addr(addr_i, A_CTRL))    rdata_o = {{(DW-CTRL_BITS){1'b0}}, ctrl_q};
    if (hit_addr(addr_i, A_MODE))    rdata_o = mode_q;
    if (hit_addr(addr_i, A_AUX))     rdata_o = aux_q;
    if (hit_addr(addr_i, A_FLAG))    rdata_o = {{(DW-FW){1'b0}}, flag_q};
    if (hit_addr(addr_i, A_CNT))     rdata_o = cnt[DW-1:0];
    if (hit_addr(addr_i, A_CNT + 1)) rdata_o = cnt[CW-1:DW];
    for (int k = 0; k < NCH; k++) begin
      if (hit_addr(addr_i, A_CH_BASE + 2*k))     rdata_o = ch_val[k][DW-1:0];
      if (hit_addr(addr_i, A_CH_BASE + 2*k + 1)) rdata_o = ch_val[k][CW-1:DW];
    end
  end

  p_flag_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~flag_clr)) == $past(flag_q & ~flag_clr)));
  p_ovf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag_o);
  p_rld_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rld_evt |=> rld_flag_o);
endmodule

// File: tb/test_cc_timer.sv
module test_cc_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int A_CTRL = 0, A_MODE = 1, A_AUX = 2, A_FLAG = 3, A_CNT = 4, A_CH0 = 6;

  logic       clk = 1'b0;
  logic       rst_n, tick_i, gate_i, count_i, reload_i, wr_en_i;
  logic [3:0] cap_i, addr_i, cmp_o, ch_flag_o;
  logic [7:0] wdata_i, rdata_o;
  logic       ovf_flag_o, rld_flag_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer i_cc_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i), .count_i(count_i),
    .reload_i(reload_i), .cap_i(cap_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cmp_o(cmp_o), .ovf_flag_o(ovf_flag_o),
    .rld_flag_o(rld_flag_o), .ch_flag_o(ch_flag_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 4'(a); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr_i = 4'(a);
    #1 d = rdata_o;
  endtask

  task automatic rd16(input int a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 1, hi);
    v = {hi, lo};
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr(A_CNT, v[7:0]);
    wr(A_CNT + 1, v[15:8]);
  endtask

  task automatic set_ch(input int k, input logic [15:0] v);
    wr(A_CH0 + 2*k, v[7:0]);
    wr(A_CH0 + 2*k + 1, v[15:8]);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic pulse_count();
    count_i = 1'b1; idle(2); count_i = 1'b0; idle(2);
  endtask

  task automatic pulse_reload();
    reload_i = 1'b1; idle(2); reload_i = 1'b0; idle(2);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c;
    logic [7:0]  f;
    logic [15:0] exp_ch [4];
    logic [15:0] cval [4];
    logic [3:0]  eo;
    int lens [3] = '{1, 5, 37};

    rst_n = 1'b0; tick_i = 0; gate_i = 0; count_i = 0; reload_i = 0; cap_i = 0;
    wr_en_i = 0; addr_i = 0; wdata_i = 0;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset state
    rd16(A_CNT, v); chk("R1 count", v, 0);
    for (int k = 0; k < 4; k++) begin rd16(A_CH0 + 2*k, v); chk("R1 channel", v, 0); end
    rd(A_FLAG, f); chk("R1 flags", f, 0);
    chk("R1 cmp_o", cmp_o, 0);

    // R2 internal tick and stop
    wr(A_CTRL, 8'h01);
    for (int i = 0; i < 3; i++) begin
      set_cnt(0); ticks(lens[i]); rd16(A_CNT, v); chk("R2 tick count", v, lens[i]);
    end
    wr(A_CTRL, 8'h00); set_cnt(16'h0100); ticks(10);
    rd16(A_CNT, v); chk("R2 stopped", v, 16'h0100);

    // R3 divide-by-two sweep
    for (int n = 0; n < 10; n++) begin
      wr(A_CTRL, 8'h02); set_cnt(0); ticks(n);
      rd16(A_CNT, v); chk("R3 div2", v, n / 2);
    end

    // R4 gate
    wr(A_CTRL, 8'h05); gate_i = 1'b0; idle(3); set_cnt(0); ticks(10);
    rd16(A_CNT, v); chk("R4 gate low", v, 0);
    gate_i = 1'b1; idle(3); ticks(7);
    rd16(A_CNT, v); chk("R4 gate high", v, 7);
    gate_i = 1'b0;

    // R5 external count
    wr(A_CTRL, 8'h03); set_cnt(0);
    for (int p = 0; p < 6; p++) pulse_count();
    idle(4); rd16(A_CNT, v); chk("R5 ext edges", v, 6);
    ticks(5); rd16(A_CNT, v); chk("R5 tick ignored", v, 6);

    // R6 overflow
    wr(A_CTRL, 8'h01); wr(A_FLAG, 8'hFF); set_cnt(16'hFFFE);
    ticks(1); idle(1); rd16(A_CNT, v); chk("R6 at top", v, 16'hFFFF);
    chk("R6 no flag yet", ovf_flag_o, 0);
    ticks(1); idle(1); rd16(A_CNT, v); chk("R6 wrap", v, 0);
    chk("R6 ovf flag", ovf_flag_o, 1);
    ticks(3); rd16(A_CNT, v); chk("R6 after wrap", v, 3);

    // R13 sticky flags, write-1-to-clear
    wr(A_FLAG, 8'h00); rd(A_FLAG, f); chk("R13 write 0 keeps", f, 8'h01);
    wr(A_FLAG, 8'h01); rd(A_FLAG, f); chk("R13 write 1 clears", f, 8'h00);

    // R7 reload on overflow
    set_ch(0, 16'h1234); wr(A_CTRL, 8'h09); set_cnt(16'hFFFD); ticks(5);
    rd16(A_CNT, v); chk("R7 reload", v, 16'h1236);
    chk("R7 ovf flag", ovf_flag_o, 1);

    // R8 external reload
    wr(A_CTRL, 8'h18); wr(A_FLAG, 8'hFF); set_cnt(16'h0055);
    pulse_reload(); idle(4);
    rd16(A_CNT, v); chk("R8 ext reload", v, 16'h1234);
    chk("R8 rld flag", rld_flag_o, 1);
    wr(A_CTRL, 8'h10); wr(A_FLAG, 8'hFF); chk("R8 flag cleared", rld_flag_o, 0);
    set_cnt(16'h0055); pulse_reload(); idle(4);
    rd16(A_CNT, v); chk("R8 reload disabled", v, 16'h0055);
    chk("R8 flag without load", rld_flag_o, 1);

    // R9 pin capture with per-channel polarity (ch0, ch2 rising; ch1, ch3 falling)
    wr(A_CTRL, 8'h00); wr(A_MODE, 8'h55); wr(A_AUX, 8'h05); wr(A_FLAG, 8'hFF);
    exp_ch[0] = 16'h1234; exp_ch[1] = 0; exp_ch[2] = 0; exp_ch[3] = 0;
    for (int k = 0; k < 4; k++) begin
      c = 16'h0107 + 16'(k) * 16'h0100;
      set_cnt(c); cap_i[k] = 1'b1; idle(4);
      if (k % 2 == 0) exp_ch[k] = c;
      rd16(A_CH0 + 2*k, v); chk("R9 after rise", v, exp_ch[k]);
      set_cnt(c + 16'h0050); cap_i[k] = 1'b0; idle(4);
      if (k % 2 == 1) exp_ch[k] = c + 16'h0050;
      rd16(A_CH0 + 2*k, v); chk("R9 after fall", v, exp_ch[k]);
    end
    rd(A_FLAG, f); chk("R9 channel flags", f, 8'h3C);

    // R10 capture by low-byte write
    wr(A_CTRL, 8'h20); wr(A_FLAG, 8'hFF); set_cnt(16'h4321);
    wr(A_CH0 + 2, 8'h99);
    rd16(A_CH0 + 2, v); chk("R10 soft capture", v, 16'h4321);
    rd(A_FLAG, f); chk("R10 flag", f, 8'h08);
    wr(A_CH0 + 3, 8'h77);
    rd16(A_CH0 + 2, v); chk("R10 high byte stores", v, 16'h7721);
    wr(A_CTRL, 8'h00); wr(A_CH0 + 4, 8'h5A);
    rd16(A_CH0 + 4, v); chk("R10 pin mode low write", v, {exp_ch[2][15:8], 8'h5A});

    // R11 compare mode 0 sweep
    wr(A_MODE, 8'hAA);
    for (int k = 0; k < 4; k++) begin cval[k] = 16'(5 + 4*k); set_ch(k, cval[k]); end
    wr(A_CTRL, 8'h01); set_cnt(0); wr(A_FLAG, 8'hFF);
    for (int s = 1; s <= 20; s++) begin
      ticks(1); idle(1);
      for (int k = 0; k < 4; k++) eo[k] = (s >= cval[k]);
      chk("R11 compare sweep", cmp_o, eo);
    end
    rd(A_FLAG, f); chk("R11 match flags", f, 8'h3C);
    set_cnt(16'hFFFE); ticks(2); idle(1);
    chk("R11 overflow clears", cmp_o, 4'b0000);

    // R12 compare mode 1 with software levels 1010
    wr(A_AUX, 8'hA0); wr(A_CTRL, 8'h41); set_cnt(0);
    for (int s = 1; s <= 20; s++) begin
      ticks(1); idle(1);
      for (int k = 0; k < 4; k++) eo[k] = (s >= cval[k]) ? (k % 2 == 1) : 1'b0;
      chk("R12 sw level sweep", cmp_o, eo);
    end
    wr(A_AUX, 8'h50); set_cnt(16'hFFFE); ticks(2); idle(1);
    chk("R12 overflow no effect", cmp_o, 4'b1010);
    ticks(5); idle(1);
    chk("R12 new level on match", cmp_o, 4'b1011);

    // R14 channels off
    wr(A_MODE, 8'h00); idle(1);
    chk("R14 outputs low", cmp_o, 4'b0000);
    wr(A_FLAG, 8'hFF); wr(A_CTRL, 8'h00); set_cnt(16'h0005);
    cap_i = 4'hF; idle(4); cap_i = 4'h0; idle(4);
    for (int k = 0; k < 4; k++) begin
      rd16(A_CH0 + 2*k, v); chk("R14 no capture", v, cval[k]);
    end
    rd(A_FLAG, f); chk("R14 no flags", f, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule